// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This block moves 32-bit values between the 32 lanes of a warp in a single registered step, with no trip through shared memory. Each lane presents its own value and a 5-bit per-lane operand. A two-bit mode picks how every lane finds the lane it reads from: a direct index, a fixed distance toward lower lanes, a fixed distance toward higher lanes, or a butterfly XOR.

A width select divides the warp into equal segments of 2, 4, 8, 16 or 32 lanes, and all source lanes are found inside the reader's own segment. A lane whose source falls outside its segment, or whose source or own lane is masked off, keeps its own value and reports its valid flag low. The result is captured one clock after the request, and a new request may be given every cycle.

Top module: `warp_shuffle`

## Requirements
- R1: While `rst_n` is low, and after it until a request is accepted, `out_valid` is 0 and `out_ok` is all zero.
- R2: Mode 0 (indexed): lane i reads lane `base + (op_i mod W)`, where W is the segment width and `base` is the first lane of the segment holding lane i.
- R3: Mode 1 (up): lane i reads lane `i - op_i`. If `op_i` is greater than i's position inside its segment, the source is out of range.
- R4: Mode 2 (down): lane i reads lane `i + op_i`. If position plus `op_i` is W or more, the source is out of range.
- R5: Mode 3 (XOR): lane i reads lane `base + (pos XOR (op_i mod W))`, where pos is i's position inside its segment.
- R6: `in_wsel` value 0, 1, 2 or 3 gives W = 2, 4, 8 or 16. Any value from 4 to 7 gives W = 32.
- R7: A lane gets `out_ok` high and the source value only when the source is in range, the source lane is active and the lane itself is active in `in_act`. Otherwise it returns its own input value with `out_ok` low.
- R8: A request accepted in cycle N shows on the outputs in cycle N+1 with `out_valid` high. Requests may follow back to back, one per cycle.
- R9: A cycle with `in_valid` low gives `out_valid` 0 and `out_ok` all zero in the next cycle, and leaves `out_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | 0 indexed, 1 up, 2 down, 3 XOR |
| in_wsel | input | 3 | Segment width select (R6) |
| in_act | input | 32 | Active lane mask, bit i for lane i |
| in_val | input | 1024 | Lane values, lane i at bits [32i+31:32i] |
| in_op | input | 160 | Per-lane operand, lane i at bits [5i+4:5i] |
| out_valid | output | 1 | Registered result present |
| out_ok | output | 32 | Per-lane flag: source value delivered |
| out_val | output | 1024 | Per-lane result, same layout as `in_val` |

## Verification
The properties assume the inputs carry known values during every cycle with `in_valid` high. They check the own-value fallback against the value of the previous cycle, so they also assume a lane's input is sampled in the cycle of its request. The stimulus drives every input at the falling edge to fixed, fully specified patterns and drops `in_valid` only on purpose. Full-mask indexed and XOR requests are what the full-delivery properties expect, so the vector set includes both and also includes partial masks that those properties leave alone.

// File: rtl/wshf_pkg.sv
package wshf_pkg;
  typedef enum logic [1:0] {
    SH_IDX  = 2'd0,
    SH_UP   = 2'd1,
    SH_DOWN = 2'd2,
    SH_XOR  = 2'd3
  } shf_mode_e;
endpackage

// File: rtl/wshf_seg_dec.sv
// Turns the width select into a mask of the in-segment position bits.
module wshf_seg_dec #(
  parameter int LANES = 32,
  parameter int IW    = $clog2(LANES),
  parameter int WSW   = 3
) (
  input  logic [WSW-1:0] wsel,
  output logic [IW-1:0]  seg_mask
);
  int seg_log;

  always_comb begin
    if (int'(wsel) >= IW - 1) seg_log = IW;
    else                      seg_log = int'(wsel) + 1;
    seg_mask = IW'((32'd1 << seg_log) - 32'd1);
  end
endmodule

// File: rtl/wshf_src_sel.sv
// Per-lane source lane computation and range test.
module wshf_src_sel
  import wshf_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int IW      = $clog2(LANES),
  parameter int LANE_ID = 0
) (
  input  shf_mode_e     mode,
  input  logic [IW-1:0] seg_mask,
  input  logic [IW-1:0] op,
  output logic [IW-1:0] src,
  output logic          in_seg
);
  localparam logic [IW-1:0] ME = IW'(LANE_ID);

  logic [IW-1:0] pos;
  logic [IW-1:0] base;
  logic [IW:0]   sum;

  always_comb begin
    pos  = ME & seg_mask;
    base = ME & ~seg_mask;
    sum  = {1'b0, pos} + {1'b0, op};
    unique case (mode)
      SH_IDX: begin
        src    = base | (op & seg_mask);
        in_seg = 1'b1;
      end
      SH_UP: begin
        src    = ME - op;
        in_seg = (op <= pos);
      end
      SH_DOWN: begin
        src    = ME + op;
        in_seg = (sum <= {1'b0, seg_mask});
      end
      default: begin
        src    = ME ^ (op & seg_mask);
        in_seg = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/wshf_xbar.sv
// Full lane crossbar with own-value fallback.
module wshf_xbar #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IW    = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] val,
  input  logic [LANES-1:0]    act,
  input  logic [LANES*IW-1:0] src,
  input  logic [LANES-1:0]    in_seg,
  output logic [LANES*DW-1:0] res,
  output logic [LANES-1:0]    ok
);
  logic [DW-1:0] v_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign v_arr[g] = val[g*DW +: DW];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IW-1:0] s;
    logic          take;
    always_comb begin
      s    = src[g*IW +: IW];
      take = in_seg[g] & act[g] & act[s];
      ok[g] = take;
      res[g*DW +: DW] = take ? v_arr[s] : v_arr[g];
    end
  end
endmodule

// File: rtl/wshf_out_reg.sv
// Output stage: next-state logic and register kept apart.
module wshf_out_reg #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [LANES-1:0]    ok_in,
  input  logic [LANES*DW-1:0] res_in,
  output logic                vld_q,
  output logic [LANES-1:0]    ok_q,
  output logic [LANES*DW-1:0] res_q
);
  logic                vld_d;
  logic [LANES-1:0]    ok_d;
  logic [LANES*DW-1:0] res_d;

  always_comb begin
    vld_d = en;
    ok_d  = en ? ok_in : '0;
    res_d = en ? res_in : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ok_q  <= '0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      ok_q  <= ok_d;
      res_q <= res_d;
    end
  end
endmodule

// File: rtl/warp_shuffle.sv
module warp_shuffle
  import wshf_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IW    = $clog2(LANES),
  parameter int WSW   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_mode,
  input  logic [WSW-1:0]      in_wsel,
  input  logic [LANES-1:0]    in_act,
  input  logic [LANES*DW-1:0] in_val,
  input  logic [LANES*IW-1:0] in_op,
  output logic                out_valid,
  output logic [LANES-1:0]    out_ok,
  output logic [LANES*DW-1:0] out_val
);
  shf_mode_e           mode;
  logic [IW-1:0]       seg_mask;
  logic [LANES*IW-1:0] src_all;
  logic [LANES-1:0]    seg_ok;
  logic [LANES*DW-1:0] xres;
  logic [LANES-1:0]    xok;

  assign mode = shf_mode_e'(in_mode);

  wshf_seg_dec #(.LANES(LANES), .IW(IW), .WSW(WSW)) seg_i (
    .wsel     (in_wsel),
    .seg_mask (seg_mask)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    wshf_src_sel #(.LANES(LANES), .IW(IW), .LANE_ID(g)) sel_i (
      .mode     (mode),
      .seg_mask (seg_mask),
      .op       (in_op[g*IW +: IW]),
      .src      (src_all[g*IW +: IW]),
      .in_seg   (seg_ok[g])
    );
  end

  wshf_xbar #(.LANES(LANES), .DW(DW), .IW(IW)) xbar_i (
    .val    (in_val),
    .act    (in_act),
    .src    (src_all),
    .in_seg (seg_ok),
    .res    (xres),
    .ok     (xok)
  );

  wshf_out_reg #(.LANES(LANES), .DW(DW)) oreg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .ok_in  (xok),
    .res_in (xres),
    .vld_q  (out_valid),
    .ok_q   (out_ok),
    .res_q  (out_val)
  );
endmodule

// File: rtl/warp_shuffle_chk.sv
module warp_shuffle_chk #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IW    = 5,
  parameter int WSW   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          in_mode,
  input logic [WSW-1:0]      in_wsel,
  input logic [LANES-1:0]    in_act,
  input logic [LANES*DW-1:0] in_val,
  input logic [LANES*IW-1:0] in_op,
  input logic                out_valid,
  input logic [LANES-1:0]    out_ok,
  input logic [LANES*DW-1:0] out_val
);
  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_val) && out_ok == '0));

  a_r7_inactive_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_ok & ~$past(in_act)) == '0));

  a_r2_full_index: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd0 && &in_act) |=> &out_ok);

  a_r5_full_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd3 && &in_act) |=> &out_ok);

  a_r3_lane0_up: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd1 && in_op[IW-1:0] != '0) |=> !out_ok[0]);

  for (genvar k = 0; k < LANES; k++) begin : g_own
    a_r7_own_value: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ok[k]) |-> out_val[k*DW +: DW] == $past(in_val[k*DW +: DW]));
  end
endmodule

bind warp_shuffle warp_shuffle_chk #(.LANES(LANES), .DW(DW), .IW(IW), .WSW(WSW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .in_wsel(in_wsel), .in_act(in_act), .in_val(in_val), .in_op(in_op),
  .out_valid(out_valid), .out_ok(out_ok), .out_val(out_val)
);

// File: tb/warp_shuffle_tb_top.sv
module warp_shuffle_tb_top;
  localparam int LANES = 32;
  localparam int DW    = 32;
  localparam int IW    = 5;
  localparam int NV    = 17;

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic [1:0]          in_mode;
  logic [2:0]          in_wsel;
  logic [LANES-1:0]    in_act;
  logic [LANES*DW-1:0] in_val;
  logic [LANES*IW-1:0] in_op;
  logic                out_valid;
  logic [LANES-1:0]    out_ok;
  logic [LANES*DW-1:0] out_val;

  int n_chk;
  int n_bad;
  bit done;

  warp_shuffle dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_wsel(in_wsel), .in_act(in_act), .in_val(in_val), .in_op(in_op),
    .out_valid(out_valid), .out_ok(out_ok), .out_val(out_val)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector fields: [43:42] mode, [41:39] width select, [38:7] active mask,
  // [6:5] operand kind (0 uniform, 1 reversed lane, 2 lane*7+v), [4:0] value.
  localparam logic [43:0] VT [NV] = '{
    {2'd0, 3'd4, 32'hFFFF_FFFF, 2'd1, 5'd0},   // R2 reverse across warp
    {2'd0, 3'd2, 32'hFFFF_FFFF, 2'd2, 5'd3},   // R2 + R6 width 8
    {2'd0, 3'd1, 32'h0F0F_00FF, 2'd0, 5'd1},   // R7 partial mask
    {2'd1, 3'd4, 32'hFFFF_FFFF, 2'd0, 5'd1},   // R3
    {2'd1, 3'd4, 32'hFFFF_FFFF, 2'd0, 5'd5},   // R3
    {2'd1, 3'd2, 32'hFFFF_FFFF, 2'd0, 5'd3},   // R3 segment bound
    {2'd1, 3'd3, 32'hFFFF_7FFE, 2'd0, 5'd2},   // R3 + R7
    {2'd2, 3'd4, 32'hFFFF_FFFF, 2'd0, 5'd1},   // R4
    {2'd2, 3'd3, 32'hFFFF_FFFF, 2'd0, 5'd7},   // R4 width 16
    {2'd2, 3'd0, 32'hFFFF_FFFF, 2'd0, 5'd1},   // R4 width 2
    {2'd3, 3'd4, 32'hFFFF_FFFF, 2'd0, 5'd16},  // R5
    {2'd3, 3'd1, 32'hFFFF_FFFF, 2'd0, 5'd3},   // R5 width 4
    {2'd3, 3'd4, 32'hAAAA_5555, 2'd0, 5'd1},   // R7 all sources inactive
    {2'd0, 3'd7, 32'hFFFF_FFFF, 2'd2, 5'd0},   // R6 select 7 acts as 32
    {2'd1, 3'd4, 32'hFFFF_FFFF, 2'd0, 5'd31},  // R3 only lane 31 reaches
    {2'd2, 3'd5, 32'hFFFF_FFFF, 2'd0, 5'd31},  // R4 + R6 only lane 0 reaches
    {2'd0, 3'd4, 32'h0000_0000, 2'd2, 5'd9}    // R7 nothing active
  };

  function automatic logic [DW-1:0] lane_val(int v, int i);
    return {8'(v + 1), 8'(i), 16'(i * 37 + v * 11)};
  endfunction

  function automatic int op_of(int kind, int ov, int i);
    case (kind)
      1:       return 31 - i;
      2:       return (i * 7 + ov) % 32;
      default: return ov;
    endcase
  endfunction

  logic [LANES*DW-1:0] exp_d [NV];
  logic [LANES-1:0]    exp_k [NV];

  task automatic build(int v);
    int md, ws, w, kind, ov, pos, base, op, src;
    bit inr;
    logic [31:0] m;
    md = int'(VT[v][43:42]); ws = int'(VT[v][41:39]);
    m = VT[v][38:7]; kind = int'(VT[v][6:5]); ov = int'(VT[v][4:0]);
    w = (ws >= 4) ? 32 : (2 << ws);
    for (int i = 0; i < LANES; i++) begin
      pos = i % w; base = i - pos; op = op_of(kind, ov, i);
      inr = 1'b1; src = i;
      case (md)
        0: src = base + (op % w);
        1: begin inr = (op <= pos); src = i - op; end
        2: begin inr = (pos + op < w); src = i + op; end
        default: src = base + (pos ^ (op % w));
      endcase
      if (inr && m[i] && m[src]) begin
        exp_k[v][i] = 1'b1;
        exp_d[v][i*DW +: DW] = lane_val(v, src);
      end else begin
        exp_k[v][i] = 1'b0;
        exp_d[v][i*DW +: DW] = lane_val(v, i);
      end
    end
  endtask

  task automatic drive(int v);
    in_valid = 1'b1;
    in_mode  = VT[v][43:42];
    in_wsel  = VT[v][41:39];
    in_act   = VT[v][38:7];
    for (int i = 0; i < LANES; i++) begin
      in_val[i*DW +: DW] = lane_val(v, i);
      in_op[i*IW +: IW]  = IW'(op_of(int'(VT[v][6:5]), int'(VT[v][4:0]), i));
    end
  endtask

  function automatic string mode_tag(int v);
    case (VT[v][43:42])
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_vec(int v);
    string td, tk;
    td = (VT[v][41:39] != 3'd4) ? "R6" : mode_tag(v);
    tk = (VT[v][38:7] != 32'hFFFF_FFFF) ? "R7" : mode_tag(v);
    n_chk++;
    if (out_valid !== 1'b1) begin
      n_bad++; $display("FAIL R8 vec %0d out_valid act=%b exp=1", v, out_valid);
    end
    n_chk++;
    if (out_ok !== exp_k[v]) begin
      n_bad++; $display("FAIL %s vec %0d out_ok act=%h exp=%h", tk, v, out_ok, exp_k[v]);
    end
    n_chk++;
    if (out_val !== exp_d[v]) begin
      n_bad++; $display("FAIL %s vec %0d out_val act=%h exp=%h", td, v, out_val, exp_d[v]);
    end
  endtask

  task automatic check1(string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    for (int v = 0; v < NV; v++) build(v);
    rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_wsel = '0;
    in_act = '0; in_val = '0; in_op = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1 out_valid in reset", 64'(out_valid), 64'd0);
    check1("R1 out_ok in reset", 64'(out_ok), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R1 out_valid after reset", 64'(out_valid), 64'd0);
    // Back-to-back vectors, one per cycle (R8)
    drive(0);
    for (int v = 1; v < NV; v++) begin
      @(negedge clk);
      check_vec(v - 1);
      drive(v);
    end
    @(negedge clk);
    check_vec(NV - 1);
    // R9: idle cycle holds data, clears flags; inputs changed to prove no effect
    in_valid = 1'b0;
    in_val = ~in_val;
    in_act = '1;
    @(negedge clk);
    check1("R9 out_valid idle", 64'(out_valid), 64'd0);
    check1("R9 out_ok idle", 64'(out_ok), 64'd0);
    n_chk++;
    if (out_val !== exp_d[NV-1]) begin
      n_bad++; $display("FAIL R9 out_val act=%h exp=%h", out_val, exp_d[NV-1]);
    end
    // R1: reset during traffic clears outputs at once
    drive(3);
    @(negedge clk);
    check_vec(3);
    drive(4);
    rst_n = 1'b0;
    #1;
    check1("R1 out_valid async reset", 64'(out_valid), 64'd0);
    check1("R1 out_ok async reset", 64'(out_ok), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(10);
    @(negedge clk);
    check_vec(10);
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule